// File: doc/BRIEF.md
# PCI Bus Transaction Phase Monitor

This block watches a 32-bit PCI bus without ever driving it. It takes the active-low framing and handshake lines (FRAME, IRDY, TRDY, STOP) together with the multiplexed command/byte-enable lines and the AD bus. From these it reconstructs each transaction as a series of clean, active-high strobes. When a transaction starts from an idle bus, the block reports the bus command and the address. During the transaction it reports every data phase that actually completes, with its data word, the byte lanes that carry meaningful data, and whether it was the last phase. At the end it gives a single end-of-transaction pulse that also says whether the target used STOP.

All bus lines are sampled on the rising clock edge and inverted inside the block, so that 1 means asserted. Each report appears on registered outputs one clock after the edge where the bus showed the event. The block suits protocol checkers, trace capture and performance counters that sit next to a PCI interface.

Top module: `pci_phase_monitor`

## Requirements
- R1: When the monitor is idle and FRAME is sampled low, that edge is the address phase. One clock later `cmd_vld` pulses for one cycle, `cmd` holds the C/BE wire value from that edge, and `addr` holds AD from that edge. C/BE never contributes to `addr`.
- R2: For a completed data phase, `xfer_be` is the bitwise inverse of the C/BE lines at the completing edge. Bit i of `xfer_be` marks byte lane i, which is AD[8i+7:8i]. A 1 means the lane carries meaningful data.
- R3: `xfer_vld` pulses one clock after a data-phase edge where IRDY and TRDY are both sampled low, and `xfer_data` then holds AD from that edge. A data-phase edge with either line high is a wait state and produces no pulse.
- R4: `xfer_last` equals 1 exactly when FRAME was sampled high at the completing edge. `txn_end` pulses in the same cycle as that final transfer.
- R5: A data-phase edge with FRAME high, IRDY low and STOP low ends the transaction even when TRDY is high. `txn_end` pulses with no transfer in that case. `txn_stop` is 1 on the `txn_end` pulse whenever STOP was sampled low on any data-phase edge of that transaction.
- R6: After a transaction ends, no new address phase is recognised until an edge where FRAME and IRDY are both sampled high. FRAME going low before that edge is ignored.
- R7: A completed data phase whose C/BE lines are all high is still reported as a transfer, with `xfer_be` equal to 0.
- R8: While `rst_n` is low, and for 2 clocks after it rises, all outputs are 0 and the monitor is held idle. The reset asserts asynchronously and releases on the clock.
- R9: A data-phase edge with FRAME and IRDY both sampled high and no final phase seen (the initiator gave up) produces a `txn_end` pulse without a transfer and returns the monitor to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI bus clock |
| rst_n | input | 1 | Active-low bus reset |
| frame_n | input | 1 | Transaction framing line, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad | input | 32 | Multiplexed address/data bus |
| cmd_vld | output | 1 | One-cycle strobe for a captured address phase |
| cmd | output | 4 | Bus command as seen on the C/BE lines |
| addr | output | 32 | Captured address |
| xfer_vld | output | 1 | One-cycle strobe for a completed data phase |
| xfer_data | output | 32 | Data word of the completed phase |
| xfer_be | output | 4 | Active-high byte-lane enables of the completed phase |
| xfer_last | output | 1 | Completed phase was the final one |
| txn_end | output | 1 | One-cycle strobe at transaction end |
| txn_stop | output | 1 | Transaction was terminated or flagged by STOP |

## Verification
Directed sequences cover several cases. A single-phase write separates address capture from data reporting. A burst with IRDY-only and TRDY-only wait states shows whether one ready line alone is wrongly taken as a transfer. A retry with STOP and no data, and a disconnect with STOP on a completing phase, separate early termination from normal completion. A master abort tests the end path that has no handshake. An illegal FRAME assertion while IRDY is still low after the final phase shows whether the return to idle is premature. An all-disabled byte-enable phase, a mid-transaction reset and a long run of random bus levels follow, all compared each clock against a behavioural model.

// File: rtl/pci_mon_pkg.sv
`timescale 1ns/1ps
package pci_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_DRAIN = 2'd2
  } mon_state_e;
endpackage

// File: rtl/pci_mon_rst_sync.sv
`timescale 1ns/1ps
module pci_mon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/pci_mon_fsm.sv
`timescale 1ns/1ps
module pci_mon_fsm
  import pci_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic irdy,
  input  logic trdy,
  input  logic stop,
  output logic addr_phase,
  output logic data_done,
  output logic fin_end,
  output logic abort_end,
  output logic stop_flag
);
  mon_state_e state, state_nxt;
  logic       stop_seen, stop_seen_nxt, stop_seen_en;
  logic       in_data;

  always_comb begin
    in_data    = (state == ST_DATA);
    addr_phase = (state == ST_IDLE) && frame;
    data_done  = in_data && irdy && trdy;
    fin_end    = in_data && !frame && irdy && (trdy || stop);
    abort_end  = in_data && !frame && !irdy;
    stop_flag  = stop_seen || (in_data && stop);

    stop_seen_en  = addr_phase || (in_data && stop);
    stop_seen_nxt = !addr_phase;

    state_nxt = state;
    unique case (state)
      ST_IDLE:  if (frame) state_nxt = ST_DATA;
      ST_DATA: begin
        if (fin_end)        state_nxt = ST_DRAIN;
        else if (abort_end) state_nxt = ST_IDLE;
      end
      ST_DRAIN: if (!frame && !irdy) state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      stop_seen <= 1'b0;
    end else begin
      state <= state_nxt;
      if (stop_seen_en) stop_seen <= stop_seen_nxt;
    end
  end
endmodule

// File: rtl/pci_mon_capture.sv
`timescale 1ns/1ps
module pci_mon_capture #(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_phase,
  input  logic            data_done,
  input  logic            fin_end,
  input  logic            abort_end,
  input  logic            stop_flag,
  input  logic            frame,
  input  logic [BE_W-1:0] cbe_n,
  input  logic [AD_W-1:0] ad,
  output logic            cmd_vld,
  output logic [BE_W-1:0] cmd,
  output logic [AD_W-1:0] addr,
  output logic            xfer_vld,
  output logic [AD_W-1:0] xfer_data,
  output logic [BE_W-1:0] xfer_be,
  output logic            xfer_last,
  output logic            txn_end,
  output logic            txn_stop
);
  logic end_evt;
  assign end_evt = fin_end || abort_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld  <= 1'b0;
      xfer_vld <= 1'b0;
      txn_end  <= 1'b0;
      txn_stop <= 1'b0;
    end else begin
      cmd_vld  <= addr_phase;
      xfer_vld <= data_done;
      txn_end  <= end_evt;
      txn_stop <= end_evt && stop_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= '0;
      addr <= '0;
    end else if (addr_phase) begin
      cmd  <= cbe_n;
      addr <= ad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_data <= '0;
      xfer_be   <= '0;
      xfer_last <= 1'b0;
    end else if (data_done) begin
      xfer_data <= ad;
      xfer_be   <= ~cbe_n;
      xfer_last <= !frame;
    end
  end
endmodule

// File: rtl/pci_phase_monitor.sv
`timescale 1ns/1ps
module pci_phase_monitor #(
  parameter int AD_W        = 32,
  parameter int SYNC_STAGES = 2,
  localparam int BE_W       = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            stop_n,
  input  logic [BE_W-1:0] cbe_n,
  input  logic [AD_W-1:0] ad,
  output logic            cmd_vld,
  output logic [BE_W-1:0] cmd,
  output logic [AD_W-1:0] addr,
  output logic            xfer_vld,
  output logic [AD_W-1:0] xfer_data,
  output logic [BE_W-1:0] xfer_be,
  output logic            xfer_last,
  output logic            txn_end,
  output logic            txn_stop
);
  logic core_rst_n;
  logic frame, irdy, trdy, stop;
  logic addr_phase, data_done, fin_end, abort_end, stop_flag;

  assign frame = !frame_n;
  assign irdy  = !irdy_n;
  assign trdy  = !trdy_n;
  assign stop  = !stop_n;

  pci_mon_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(core_rst_n)
  );

  pci_mon_fsm i_fsm (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .frame     (frame),
    .irdy      (irdy),
    .trdy      (trdy),
    .stop      (stop),
    .addr_phase(addr_phase),
    .data_done (data_done),
    .fin_end   (fin_end),
    .abort_end (abort_end),
    .stop_flag (stop_flag)
  );

  pci_mon_capture #(.AD_W(AD_W), .BE_W(BE_W)) i_capture (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .addr_phase(addr_phase),
    .data_done (data_done),
    .fin_end   (fin_end),
    .abort_end (abort_end),
    .stop_flag (stop_flag),
    .frame     (frame),
    .cbe_n     (cbe_n),
    .ad        (ad),
    .cmd_vld   (cmd_vld),
    .cmd       (cmd),
    .addr      (addr),
    .xfer_vld  (xfer_vld),
    .xfer_data (xfer_data),
    .xfer_be   (xfer_be),
    .xfer_last (xfer_last),
    .txn_end   (txn_end),
    .txn_stop  (txn_stop)
  );
endmodule

// File: rtl/pci_mon_checker.sv
`timescale 1ns/1ps
module pci_mon_checker #(
  parameter int AD_W = 32,
  localparam int BE_W = AD_W / 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_n,
  input logic            irdy_n,
  input logic            trdy_n,
  input logic            stop_n,
  input logic [BE_W-1:0] cbe_n,
  input logic [AD_W-1:0] ad,
  input logic            cmd_vld,
  input logic [BE_W-1:0] cmd,
  input logic [AD_W-1:0] addr,
  input logic            xfer_vld,
  input logic [AD_W-1:0] xfer_data,
  input logic [BE_W-1:0] xfer_be,
  input logic            xfer_last,
  input logic            txn_end,
  input logic            txn_stop
);
  a_r1_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (addr == $past(ad)) && (cmd == $past(cbe_n)) && !$past(frame_n));

  a_r2_be_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> xfer_be == ~$past(cbe_n));

  a_r3_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> !$past(irdy_n) && !$past(trdy_n) && (xfer_data == $past(ad)));

  a_r4_last_frame: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> xfer_last == $past(frame_n));

  a_r4_end_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |=> !xfer_vld && !txn_end);

  a_r5_stop_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !$past(stop_n)) |-> txn_stop);

  a_r5_stop_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    txn_stop |-> txn_end);

  a_r6_no_cmd_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> !xfer_vld && !txn_end);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_quiet: assert (!cmd_vld && !xfer_vld && !txn_end && !txn_stop);
    end
  end
endmodule

bind pci_phase_monitor pci_mon_checker #(.AD_W(AD_W)) i_chk (.*);

// File: tb/test_pci_phase_monitor.sv
`timescale 1ns/1ps
module test_pci_phase_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, trdy_n, stop_n;
  logic [3:0]  cbe_n;
  logic [31:0] ad;
  logic        cmd_vld, xfer_vld, xfer_last, txn_end, txn_stop;
  logic [3:0]  cmd, xfer_be;
  logic [31:0] addr, xfer_data;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pci_phase_monitor i_pci_phase_monitor (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .cbe_n(cbe_n), .ad(ad),
    .cmd_vld(cmd_vld), .cmd(cmd), .addr(addr), .xfer_vld(xfer_vld),
    .xfer_data(xfer_data), .xfer_be(xfer_be), .xfer_last(xfer_last),
    .txn_end(txn_end), .txn_stop(txn_stop)
  );

  // behavioural reference
  int          mode;      // 0 idle, 1 in transaction, 2 waiting for idle bus
  int          released;
  bit          stop_hist;
  bit          m_cmd_vld, m_xfer_vld, m_last, m_end, m_stop, m_abort, m_reset;
  logic [3:0]  m_cmd, m_be;
  logic [31:0] m_addr, m_data;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit f, i, t, s;
    f = !frame_n; i = !irdy_n; t = !trdy_n; s = !stop_n;
    m_cmd_vld = 0; m_xfer_vld = 0; m_end = 0; m_stop = 0; m_abort = 0;
    if (!rst_n || released < 2) begin
      if (!rst_n) released = 0; else released++;
      m_reset = 1; mode = 0; stop_hist = 0;
      m_cmd = 0; m_addr = 0; m_data = 0; m_be = 0; m_last = 0;
    end else begin
      m_reset = 0;
      if (mode == 0) begin
        if (f) begin
          m_cmd_vld = 1; m_cmd = cbe_n; m_addr = ad; mode = 1; stop_hist = 0;
        end
      end else if (mode == 1) begin
        if (i && t) begin
          m_xfer_vld = 1; m_data = ad; m_be = ~cbe_n; m_last = !f;
        end
        stop_hist = stop_hist | s;
        if (!f && i && (t || s)) begin
          m_end = 1; m_stop = stop_hist; mode = 2;
        end else if (!f && !i) begin
          m_end = 1; m_stop = stop_hist; m_abort = 1; mode = 0;
        end
      end else if (!f && !i) begin
        mode = 0;
      end
    end
    #1;
    if (m_reset) begin
      check("R8 cmd_vld", 32'(cmd_vld), 32'(m_cmd_vld));
      check("R8 xfer_vld", 32'(xfer_vld), 0);
      check("R8 txn_end", 32'(txn_end), 0);
      check("R8 addr", addr, 0);
    end else begin
      check("R1 R6 cmd_vld", 32'(cmd_vld), 32'(m_cmd_vld));
      if (m_cmd_vld) begin
        check("R1 cmd", 32'(cmd), 32'(m_cmd));
        check("R1 addr", addr, m_addr);
      end
      check("R3 xfer_vld", 32'(xfer_vld), 32'(m_xfer_vld));
      if (m_xfer_vld) begin
        check("R3 xfer_data", xfer_data, m_data);
        check(m_be == 0 ? "R7 xfer_be" : "R2 xfer_be", 32'(xfer_be), 32'(m_be));
        check("R4 xfer_last", 32'(xfer_last), 32'(m_last));
      end
      check(m_abort ? "R9 txn_end" : "R4 txn_end", 32'(txn_end), 32'(m_end));
      check("R5 txn_stop", 32'(txn_stop), 32'(m_stop));
    end
  end

  task automatic bus(input bit f, input bit i, input bit t, input bit s,
                     input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    frame_n = !f; irdy_n = !i; trdy_n = !t; stop_n = !s; cbe_n = be; ad = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) bus(0, 0, 0, 0, 4'hF, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    released = 0; mode = 0;
    rst_n = 1'b0; frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1;
    cbe_n = 4'hF; ad = 32'h0;
    repeat (3) @(negedge clk);
    // R8: reset state including the release window
    rst_n = 1'b1;
    idle(4);
    // R1 R3 R4: single-phase write
    bus(1, 0, 0, 0, 4'h7, 32'h1000_0040);
    bus(0, 1, 1, 0, 4'h0, 32'hDEAD_BEEF);
    idle(2);
    // R3 R2: burst with wait states on each side
    bus(1, 0, 0, 0, 4'h6, 32'h2000_0000);
    bus(1, 1, 0, 0, 4'hE, 32'h1111_1111);
    bus(1, 0, 1, 0, 4'hE, 32'h2222_2222);
    bus(1, 1, 1, 0, 4'hC, 32'h3333_3333);
    bus(1, 1, 1, 0, 4'h3, 32'h4444_4444);
    bus(0, 1, 0, 0, 4'h5, 32'h5555_5555);
    bus(0, 1, 1, 0, 4'hA, 32'h6666_6666);
    idle(2);
    // R5: retry, STOP with no data
    bus(1, 0, 0, 0, 4'h6, 32'h3000_0000);
    bus(1, 1, 0, 1, 4'h0, 32'h0);
    bus(0, 1, 0, 1, 4'h0, 32'h0);
    idle(2);
    // R5: disconnect with data
    bus(1, 0, 0, 0, 4'h7, 32'h3100_0000);
    bus(1, 1, 1, 1, 4'h0, 32'hCAFE_0001);
    bus(0, 1, 0, 1, 4'h0, 32'h0);
    idle(2);
    // R7: all lanes disabled
    bus(1, 0, 0, 0, 4'h7, 32'h4000_0000);
    bus(0, 1, 1, 0, 4'hF, 32'h7777_7777);
    idle(2);
    // R9: master abort
    bus(1, 0, 0, 0, 4'h6, 32'h5000_0000);
    bus(0, 1, 0, 0, 4'h0, 32'h0);
    bus(0, 0, 0, 0, 4'hF, 32'h0);
    idle(2);
    // R6: FRAME low while IRDY still low after the final phase
    bus(1, 0, 0, 0, 4'h7, 32'h6000_0000);
    bus(0, 1, 1, 0, 4'h0, 32'h8888_8888);
    bus(1, 1, 0, 0, 4'h6, 32'h6100_0000);
    bus(0, 0, 0, 0, 4'hF, 32'h0);
    bus(1, 0, 0, 0, 4'h6, 32'h6200_0000);
    bus(0, 1, 1, 0, 4'h0, 32'h9999_9999);
    idle(2);
    // R8: reset in the middle of a transaction
    bus(1, 0, 0, 0, 4'h7, 32'h7000_0000);
    bus(1, 1, 1, 0, 4'h0, 32'hAAAA_AAAA);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
    // random bus levels
    for (int k = 0; k < 3000; k++)
      bus(($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 2) != 0,
          ($urandom % 5) == 0, 4'($urandom), $urandom);
    idle(3);
    finish_run();
  end
endmodule